// File: doc/BRIEF.md
# DDC Adaptor Identification Target

This block is an I2C target that sits on a display data channel. A graphics source uses it to tell that a DisplayPort-to-HDMI adaptor is attached, by reading a short fixed ASCII phrase. The bus lines are open-drain. The block samples SCL and SDA, and it pulls SDA low through a single enable output. It never drives SCL, so it does not stretch the clock.

The block sees only its own write/read address pair. A write sets the sub-address pointer. Reads then stream bytes from a small computed store and move the pointer on after each byte. The target responds only while the HDMI/DVI output path is selected. When that path is deselected, the target releases the bus at once. The pointer survives STOP and repeated START, so a source can set an offset and then read from it in a later transaction.

Top module: `ddc_id_target`

## Requirements
- R1: After reset SDA is released (`sda_pull_o` = 0) and the pointer is 00h, so a read with no prior offset write returns 44h first.
- R2: The target acknowledges address byte 80h (write) and 81h (read). Bits 7:1 of the address byte hold the 7-bit address 40h and bit 0 gives the direction, with 1 meaning read.
- R3: Any other address byte gets no acknowledge, and the target leaves SDA released until the next START.
- R4: While `sink_sel_i` is low the target acknowledges nothing. A fall of `sink_sel_i` releases SDA on the next clock and abandons the transfer in flight, even when it comes during the last bit of a byte.
- R5: Offsets 00h..0Fh read as 44 50 2D 48 44 4D 49 20 41 44 41 50 54 4F 52 04 (hex), and offset 10h reads FFh.
- R6: The first data byte after address 80h loads the pointer. Later data bytes in the same write are acknowledged and have no effect.
- R7: Each byte read moves the pointer on by one. The pointer is kept across repeated START and across STOP.
- R8: Every offset above 10h reads FFh. The pointer stops at FFh and never wraps.
- R9: The acknowledge pulls SDA low from the SCL fall after the eighth bit until the fall after the ninth. SDA pulls start only on SCL falls, and SDA is released after a read byte that the master does not acknowledge.
- R10: A STOP returns the target to idle and releases SDA. Bytes clocked after a STOP with no START get no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| sink_sel_i | input | 1 | High while the HDMI/DVI output path is selected |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Two events can land in the same cycle: deselection and the decision to acknowledge a completed byte. The bench drops `sink_sel_i` just before the final address bit is clocked, and the engine must give deselection priority, so the ninth clock must read high. Deselection can also fall in the cycle where a read byte starts driving a zero bit. The bench provokes this by dropping `sink_sel_i` while the target pulls SDA for the first bit of 44h, and it expects the line released within two clocks.

// File: rtl/ddc_id_pkg.sv
package ddc_id_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK
    } eng_st_e;

    localparam logic [6:0] ID_DEV_ADDR = 7'h40;
    localparam int unsigned ID_LAST_OFS = 16;

    // identification phrase, offset 10h and beyond read as all ones
    function automatic logic [7:0] id_char(input logic [4:0] ofs);
        logic [7:0] c;
        case (ofs)
            5'h00:   c = 8'h44;
            5'h01:   c = 8'h50;
            5'h02:   c = 8'h2D;
            5'h03:   c = 8'h48;
            5'h04:   c = 8'h44;
            5'h05:   c = 8'h4D;
            5'h06:   c = 8'h49;
            5'h07:   c = 8'h20;
            5'h08:   c = 8'h41;
            5'h09:   c = 8'h44;
            5'h0A:   c = 8'h41;
            5'h0B:   c = 8'h50;
            5'h0C:   c = 8'h54;
            5'h0D:   c = 8'h4F;
            5'h0E:   c = 8'h52;
            5'h0F:   c = 8'h04;
            default: c = 8'hFF;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ddc_id_sync.sv
module ddc_id_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic prev_o
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sync_s;

    sync_s q, d;

    always_comb begin
        d      = q;
        d.pipe = {q.pipe[STAGES-2:0], line_i};
        d.prev = q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign lvl_o  = q.pipe[STAGES-1];
    assign prev_o = q.prev;
endmodule

// File: rtl/ddc_id_rom.sv
module ddc_id_rom
    import ddc_id_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic [PTR_W-1:0] ofs_i,
    output logic [7:0]       data_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ID_LAST_OFS);

    always_comb begin
        if (ofs_i > LAST) data_o = 8'hFF;
        else              data_o = id_char(5'(ofs_i));
    end
endmodule

// File: rtl/ddc_id_engine.sv
module ddc_id_engine
    import ddc_id_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             sda_lvl_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [7:0]       rom_data_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             ptr_adv_o,
    output logic             pull_o
);
    localparam logic [PTR_W-1:0] PTR_MAX = '1;

    typedef struct packed {
        eng_st_e          st;
        logic [2:0]       bcnt;
        logic [7:0]       sh;
        logic [PTR_W-1:0] ptr;
        logic             rw;
        logic             first;
        logic             ack_on;
        logic             pull;
    } eng_s;

    eng_s q, d;
    logic [7:0] byte_in;
    logic       adv_d;

    always_comb begin
        d       = q;
        adv_d   = 1'b0;
        byte_in = {q.sh[6:0], sda_lvl_i};
        if (!sel_i || stop_i) begin
            d.st     = ST_IDLE;
            d.pull   = 1'b0;
            d.ack_on = 1'b0;
        end else if (start_i) begin
            d.st     = ST_ADDR;
            d.bcnt   = 3'd0;
            d.pull   = 1'b0;
            d.ack_on = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        d.sh = byte_in;
                        if (q.bcnt == 3'd7) begin
                            d.bcnt = 3'd0;
                            if (byte_in[7:1] == ID_DEV_ADDR) begin
                                d.st     = ST_AACK;
                                d.rw     = byte_in[0];
                                d.first  = 1'b1;
                                d.ack_on = 1'b0;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.bcnt = q.bcnt + 3'd1;
                        end
                    end
                end
                ST_WDAT: begin
                    if (scl_rise_i) begin
                        d.sh = byte_in;
                        if (q.bcnt == 3'd7) begin
                            d.bcnt   = 3'd0;
                            d.st     = ST_WACK;
                            d.ack_on = 1'b0;
                            if (q.first) begin
                                d.ptr   = PTR_W'(byte_in);
                                d.first = 1'b0;
                            end
                        end else begin
                            d.bcnt = q.bcnt + 3'd1;
                        end
                    end
                end
                ST_AACK, ST_WACK: begin
                    if (scl_fall_i) begin
                        if (!q.ack_on) begin
                            d.pull   = 1'b1;
                            d.ack_on = 1'b1;
                        end else begin
                            d.ack_on = 1'b0;
                            d.bcnt   = 3'd0;
                            if (q.st == ST_AACK && q.rw) begin
                                d.st   = ST_RDAT;
                                d.sh   = rom_data_i;
                                d.pull = ~rom_data_i[7];
                            end else begin
                                d.st   = ST_WDAT;
                                d.pull = 1'b0;
                            end
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise_i) begin
                        if (q.bcnt == 3'd7) begin
                            d.bcnt   = 3'd0;
                            d.st     = ST_RACK;
                            d.ack_on = 1'b0;
                            adv_d    = 1'b1;
                            d.ptr    = (q.ptr == PTR_MAX) ? q.ptr : q.ptr + 1'b1;
                        end else begin
                            d.bcnt = q.bcnt + 3'd1;
                        end
                    end else if (scl_fall_i) begin
                        d.pull = ~q.sh[3'd7 - q.bcnt];
                    end
                end
                ST_RACK: begin
                    if (scl_fall_i) begin
                        if (q.ack_on) begin
                            d.st     = ST_RDAT;
                            d.sh     = rom_data_i;
                            d.pull   = ~rom_data_i[7];
                            d.bcnt   = 3'd0;
                            d.ack_on = 1'b0;
                        end else begin
                            d.pull = 1'b0;
                        end
                    end else if (scl_rise_i) begin
                        if (sda_lvl_i) d.st     = ST_IDLE;
                        else           d.ack_on = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.bcnt   <= '0;
            q.sh     <= '0;
            q.ptr    <= '0;
            q.rw     <= 1'b0;
            q.first  <= 1'b0;
            q.ack_on <= 1'b0;
            q.pull   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ptr_o     = q.ptr;
    assign ptr_adv_o = adv_d;
    assign pull_o    = q.pull;
endmodule

// File: rtl/ddc_id_target.sv
module ddc_id_target #(
    parameter int SYNC_STAGES = 2,
    parameter int PTR_W       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sink_sel_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    logic w_scl_lvl, w_scl_prev, w_sda_lvl, w_sda_prev;
    logic w_scl_rise, w_scl_fall, w_start, w_stop;
    logic [PTR_W-1:0] w_ptr;
    logic [7:0]       w_rom;
    logic             w_ptr_adv;

    ddc_id_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .lvl_o(w_scl_lvl), .prev_o(w_scl_prev)
    );

    ddc_id_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .lvl_o(w_sda_lvl), .prev_o(w_sda_prev)
    );

    assign w_scl_rise = w_scl_lvl & ~w_scl_prev;
    assign w_scl_fall = ~w_scl_lvl & w_scl_prev;
    assign w_start    = w_scl_lvl & w_scl_prev & w_sda_prev & ~w_sda_lvl;
    assign w_stop     = w_scl_lvl & w_scl_prev & ~w_sda_prev & w_sda_lvl;

    ddc_id_rom #(.PTR_W(PTR_W)) u_rom (
        .ofs_i(w_ptr), .data_o(w_rom)
    );

    ddc_id_engine #(.PTR_W(PTR_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .sel_i(sink_sel_i),
        .sda_lvl_i(w_sda_lvl), .scl_rise_i(w_scl_rise), .scl_fall_i(w_scl_fall),
        .start_i(w_start), .stop_i(w_stop), .rom_data_i(w_rom),
        .ptr_o(w_ptr), .ptr_adv_o(w_ptr_adv), .pull_o(sda_pull_o)
    );
endmodule

// File: rtl/ddc_id_chk.sv
module ddc_id_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             pull,
    input logic             scl_fall,
    input logic             stop_det,
    input logic             ptr_adv,
    input logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] PMAX = '1;

    a_r4_desel_release: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !pull);

    a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !pull);

    a_r9_pull_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull) |-> $past(scl_fall));

    a_r8_ptr_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_adv && ptr == PMAX) |=> ptr == PMAX);

    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_adv && ptr != PMAX) |=> ptr == $past(ptr) + 1'b1);
endmodule

bind ddc_id_target ddc_id_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sink_sel_i), .pull(sda_pull_o),
    .scl_fall(w_scl_fall), .stop_det(w_stop), .ptr_adv(w_ptr_adv), .ptr(w_ptr)
);

// File: tb/ddc_id_target_tb.sv
module ddc_id_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;

    logic clk = 1'b0, rst_n = 1'b0, sel = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
    logic sda_pull, sda_line;
    int   n_vec = 0, n_bad = 0;
    logic [7:0] mptr = 8'h00;
    bit   done = 1'b0;

    assign sda_line = sda_m & ~sda_pull;
    always #(CLK_PERIOD/2) clk = ~clk;

    ddc_id_target u_dut (
        .clk(clk), .rst_n(rst_n), .sink_sel_i(sel),
        .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull)
    );

    function automatic logic [7:0] exp_id(input logic [7:0] o);
        case (o)
            8'h00: return 8'h44; 8'h01: return 8'h50; 8'h02: return 8'h2D;
            8'h03: return 8'h48; 8'h04: return 8'h44; 8'h05: return 8'h4D;
            8'h06: return 8'h49; 8'h07: return 8'h20; 8'h08: return 8'h41;
            8'h09: return 8'h44; 8'h0A: return 8'h41; 8'h0B: return 8'h50;
            8'h0C: return 8'h54; 8'h0D: return 8'h4F; 8'h0E: return 8'h52;
            8'h0F: return 8'h04;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] sat_inc(input logic [7:0] p);
        return (p == 8'hFF) ? p : p + 8'd1;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input int drop_bit, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            if (i == drop_bit) sel = 1'b0;
            sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0;
        end
        sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] o, input string tag);
        logic a;
        i2c_start();
        send_byte(8'h80, -1, a); chk({tag, " addr 80 ack"}, {7'd0, a}, 8'd1);
        send_byte(o, -1, a);     chk({tag, " offset ack"}, {7'd0, a}, 8'd1);
        mptr = o;
    endtask

    task automatic read_n(input int n, input string tag);
        logic a;
        logic [7:0] b;
        i2c_start();
        send_byte(8'h81, -1, a); chk({tag, " addr 81 ack"}, {7'd0, a}, 8'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n-1, b);
            chk({tag, " data"}, b, exp_id(mptr));
            mptr = sat_inc(mptr);
        end
        i2c_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        void'($urandom(32'd20240611));
        tick(4);
        chk("R1 reset release", {7'd0, sda_pull}, 8'd0);
        rst_n = 1'b1; tick(4);
        chk("R1 idle after reset", {7'd0, sda_pull}, 8'd0);
        read_n(2, "R1 R2 read from reset pointer");

        // R3 unmatched addresses
        i2c_start(); send_byte(8'hA0, -1, a); chk("R3 addr A0 nack", {7'd0, a}, 8'd0);
        send_byte(8'h00, -1, a); chk("R3 following byte nack", {7'd0, a}, 8'd0);
        i2c_stop();
        i2c_start(); send_byte(8'h82, -1, a); chk("R3 addr 82 nack", {7'd0, a}, 8'd0);
        i2c_stop();

        // R4 deselected
        sel = 1'b0; tick(2);
        i2c_start(); send_byte(8'h80, -1, a); chk("R4 deselected nack", {7'd0, a}, 8'd0);
        i2c_stop(); sel = 1'b1; tick(2);
        i2c_start(); send_byte(8'h80, 0, a); chk("R4 drop at last bit nack", {7'd0, a}, 8'd0);
        i2c_stop(); sel = 1'b1; tick(2);

        // R6 extra data discarded, pointer held across repeated START
        i2c_start();
        send_byte(8'h80, -1, a); chk("R2 write addr ack", {7'd0, a}, 8'd1);
        send_byte(8'h05, -1, a); chk("R6 offset ack", {7'd0, a}, 8'd1);
        send_byte(8'h0A, -1, a); chk("R6 extra byte ack", {7'd0, a}, 8'd1);
        send_byte(8'h0B, -1, a); chk("R6 extra byte ack", {7'd0, a}, 8'd1);
        mptr = 8'h05;
        read_n(2, "R6 R7 repeated start read");

        // R7 pointer kept across STOP
        set_ptr(8'h08, "R7"); read_n(2, "R7 first");
        read_n(1, "R7 after stop");

        // R5 whole phrase plus 10h
        set_ptr(8'h00, "R5"); read_n(17, "R5 phrase");

        // R8 beyond the end and saturation
        set_ptr(8'h0F, "R8"); read_n(3, "R8 end");
        set_ptr(8'hFE, "R8"); read_n(3, "R8 sat");
        set_ptr(8'hFF, "R8"); read_n(2, "R8 no wrap");

        // R9 nack release
        set_ptr(8'h00, "R9"); read_n(1, "R9 single");
        chk("R9 released after nack", {7'd0, sda_pull}, 8'd0);

        // R4 drop while target drives a zero bit of 44h
        set_ptr(8'h00, "R4");
        i2c_start(); send_byte(8'h81, -1, a); chk("R4 read addr ack", {7'd0, a}, 8'd1);
        chk("R4 driving bit7 of 44", {7'd0, sda_pull}, 8'd1);
        sel = 1'b0; tick(2);
        chk("R4 release on deselect", {7'd0, sda_pull}, 8'd0);
        i2c_stop(); sel = 1'b1; tick(2);

        // R10 bytes after STOP without START
        send_byte(8'h80, -1, a); chk("R10 no start nack", {7'd0, a}, 8'd0);
        i2c_start(); i2c_stop();
        chk("R10 idle after stop", {7'd0, sda_pull}, 8'd0);

        // random transactions
        for (int it = 0; it < 30; it++) begin
            int kind = $urandom % 8;
            logic [7:0] o = 8'($urandom % 20);
            int n = 1 + ($urandom % 4);
            if (kind == 0) begin
                sel = 1'b0; tick(2);
                i2c_start(); send_byte(8'h80, -1, a); chk("R4 rand deselected", {7'd0, a}, 8'd0);
                i2c_stop(); sel = 1'b1; tick(2);
            end else if (kind == 1) begin
                logic [7:0] ad = 8'($urandom);
                if (ad[7:1] == 7'h40) ad = 8'h90;
                i2c_start(); send_byte(ad, -1, a); chk("R3 rand address", {7'd0, a}, 8'd0);
                i2c_stop();
            end else begin
                set_ptr(o, "R6 rand");
                read_n(n, "R5 R7 R8 rand");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule